// File: doc/BRIEF.md
# Two-Level Round-Robin Output Port Arbiter

This block decides which input port may drive one output port of a packet switch. Every input port that holds a packet for this output raises its request bit, and marks the request as urgent or normal. A packet that may leave through any output of a group raises its request on all of those outputs at once. The arbiter grants the output to exactly one requester. That requester keeps the output until the input reports the end of its packet, either as a normal end marker or as an error end marker. If the optional watchdog is on and the packet stops moving, the arbiter clears the path instead.

Urgent requests are always served before normal ones. Within one priority level, a pointer rotates modulo the number of ports, starting after the port that last held the output. The last holder therefore goes to the back of the queue. The watchdog counts the cycles in which the granted input moves no data. When the count reaches a programmable limit, the grant is withdrawn and a one-cycle error pulse is raised. One instance of the block serves each output port. Instances on different outputs may grant different inputs at the same time.

Top module: `pri_rr_arb`

## Requirements
- R1: `grant_o` never has more than one bit set.
- R2: Among requesters of equal priority, the grant goes to the first requesting port found when counting upward from the previous holder, plus one, modulo N. The previous holder itself is considered last. With holder 3, requests on ports 1 and 3 grant port 1.
- R3: If any requester has its `hi_pri_i` bit set to 1, the grant goes to a port with `hi_pri_i` = 1, whatever the pointer position.
- R4: While the output is free, a request seen at a rising edge is granted from that edge on. Only a port whose `req_i` bit was 1 can be granted. With no requests, `grant_o` stays all zero.
- R5: With `wdog_en_i` = 0, a grant stays unchanged for as long as `end_i` is not asserted, whatever other requests arrive.
- R6: At the edge where `end_i` is 1, the grant is released and re-arbitrated in the same edge. A waiting requester receives the output in the very next cycle, and the releasing port ranks last.
- R7: With `wdog_en_i` = 1, a grant is withdrawn at the edge that closes L consecutive granted cycles with neither `xfer_i` nor `end_i`, where L = `tmo_limit_i`. A limit of 0 acts as 1. At that same edge, the other requesters are re-arbitrated.
- R8: A cycle with `xfer_i` = 1 restarts the count of idle cycles from zero.
- R9: `tmo_err_o` is 1 for exactly the cycle in which a withdrawal by the watchdog takes effect. It is never raised while `wdog_en_i` = 0.
- R10: After reset, no grant is held and `tmo_err_o` is 0. The pointer acts as though port N-1 was the last holder, so port 0 ranks first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request from each input port |
| hi_pri_i | input | N | Urgent flag for each request (1 = high priority) |
| xfer_i | input | 1 | Granted input moved a data character this cycle |
| end_i | input | 1 | Granted input delivered its end marker (normal or error) |
| wdog_en_i | input | 1 | Enables the stall watchdog |
| tmo_limit_i | input | CNT_W | Idle cycles allowed before a stall is declared |
| grant_o | output | N | One-hot grant, all zero when the output is free |
| tmo_err_o | output | 1 | One-cycle pulse on a watchdog withdrawal |

## Verification
The bench grants each of the eleven ports in turn and then offers the output to every port at once. A pointer that is off by one, or that fails to wrap at port 10, hands the output to the wrong port. Hundreds of mixed request and priority patterns are compared against an arithmetic distance model. This catches a design that lets a normal request beat an urgent one, or that ranks the previous holder too highly. Timed stalls with limits 5 and 0, and one stall interrupted by a data transfer, expose a watchdog that fires a cycle early or late, fails to restart, or misses the pulse. A long hold in blocking mode, followed by an end marker, exposes a design that drops the grant early or leaves an idle cycle before the handover.

// File: rtl/pra_pkg.sv
package pra_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    localparam int NUM_LVL = 2;   // level 0: urgent, level 1: all requests

    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pra_rr_pick.sv
// Rotating pick: first set bit counting upward from last_idx + 1, modulo N.
module pra_rr_pick #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     cand,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     win_oh
);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        // scan from the farthest offset to the nearest; the nearest hit is kept
        for (int off = N; off >= 1; off--) begin
            if (cand[(int'(last_idx) + off) % N]) begin
                found   = 1'b1;
                win_idx = IDX_W'((int'(last_idx) + off) % N);
            end
        end
        win_oh = found ? (N'(1) << win_idx) : '0;
    end

endmodule

// File: rtl/pra_wdog.sv
// Idle-cycle counter for the granted path.
module pra_wdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             en,
    input  logic             clear,
    input  logic             rearm,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        expire  = active && en && !clear && (cnt_inc >= {1'b0, limit});
        st_d    = st_q;
        if (!active || !en || clear || rearm) begin
            st_d.cnt = '0;
        end else if (!(&st_q.cnt)) begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pri_rr_arb.sv
module pri_rr_arb #(
    parameter int N     = 11,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     hi_pri_i,
    input  logic             xfer_i,
    input  logic             end_i,
    input  logic             wdog_en_i,
    input  logic [CNT_W-1:0] tmo_limit_i,
    output logic [N-1:0]     grant_o,
    output logic             tmo_err_o
);
    import pra_pkg::*;

    localparam int IDX_W = idx_width(N);
    localparam logic [IDX_W-1:0] RST_LAST = IDX_W'(N - 1);

    typedef struct packed {
        phase_e           phase;
        logic [N-1:0]     grant;
        logic [IDX_W-1:0] last;
        logic             tmo;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_LVL-1:0][N-1:0]     lvl_cand;
    logic [NUM_LVL-1:0]            lvl_found;
    logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx;
    logic [NUM_LVL-1:0][N-1:0]     lvl_oh;

    logic holding;
    logic release_now;
    logic expire;

    assign lvl_cand[0] = req_i & hi_pri_i;
    assign lvl_cand[1] = req_i;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        pra_rr_pick #(
            .N     (N),
            .IDX_W (IDX_W)
        ) u_pick (
            .cand     (lvl_cand[g]),
            .last_idx (st_q.last),
            .found    (lvl_found[g]),
            .win_idx  (lvl_idx[g]),
            .win_oh   (lvl_oh[g])
        );
    end

    assign holding     = (st_q.phase == PH_HOLD);
    assign release_now = holding && (end_i || expire);

    pra_wdog #(
        .CNT_W (CNT_W)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (holding),
        .en     (wdog_en_i),
        .clear  (xfer_i || end_i),
        .rearm  (release_now),
        .limit  (tmo_limit_i),
        .expire (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.tmo = expire;
        if (!holding || release_now) begin
            if (lvl_found[0]) begin
                st_d.phase = PH_HOLD;
                st_d.grant = lvl_oh[0];
                st_d.last  = lvl_idx[0];
            end else if (lvl_found[1]) begin
                st_d.phase = PH_HOLD;
                st_d.grant = lvl_oh[1];
                st_d.last  = lvl_idx[1];
            end else begin
                st_d.phase = PH_IDLE;
                st_d.grant = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.grant <= '0;
            st_q.last  <= RST_LAST;
            st_q.tmo   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o   = st_q.grant;
    assign tmo_err_o = st_q.tmo;

endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
    parameter int N     = 11,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_i,
    input logic [N-1:0]     hi_pri_i,
    input logic             xfer_i,
    input logic             end_i,
    input logic             wdog_en_i,
    input logic [CNT_W-1:0] tmo_limit_i,
    input logic [N-1:0]     grant_o,
    input logic             tmo_err_o
);

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r4_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && grant_o != $past(grant_o)) |-> (($past(req_i) & grant_o) != '0));

    a_r3_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != $past(grant_o) && (($past(req_i) & $past(hi_pri_i)) != '0))
            |-> ((grant_o & $past(hi_pri_i)) != '0));

    a_r5_hold_blocking: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !end_i && !wdog_en_i) |=> (grant_o == $past(grant_o)));

    a_r9_tmo_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> ($past(grant_o) != '0 && $past(wdog_en_i) && !$past(end_i) && !$past(xfer_i)));

    a_r9_no_tmo_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !wdog_en_i |=> !tmo_err_o);

endmodule

bind pri_rr_arb pra_checker #(
    .N     (N),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .hi_pri_i    (hi_pri_i),
    .xfer_i      (xfer_i),
    .end_i       (end_i),
    .wdog_en_i   (wdog_en_i),
    .tmo_limit_i (tmo_limit_i),
    .grant_o     (grant_o),
    .tmo_err_o   (tmo_err_o)
);

// File: tb/tb_pri_rr_arb.sv
module tb_pri_rr_arb;
    localparam int N          = 11;
    localparam int CW         = 8;
    localparam int CLK_PERIOD = 10;
    localparam logic [N-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  hi = '0;
    logic          xfer = 1'b0;
    logic          end_s = 1'b0;
    logic          wd_en = 1'b0;
    logic [CW-1:0] limit = '0;
    logic [N-1:0]  grant_o;
    logic          tmo_err_o;

    int  total = 0;
    int  bad = 0;
    int  last_m = N - 1;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pri_rr_arb #(.N(N), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .hi_pri_i(hi), .xfer_i(xfer),
        .end_i(end_s), .wdog_en_i(wd_en), .tmo_limit_i(limit),
        .grant_o(grant_o), .tmo_err_o(tmo_err_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // distance model: smallest upward distance from last holder, urgent pool first
    function automatic int model_pick(input logic [N-1:0] r, input logic [N-1:0] h, input int last);
        int best;
        int bd;
        int d;
        logic [N-1:0] pool;
        best = -1;
        bd   = N + 1;
        pool = ((r & h) != '0) ? (r & h) : r;
        for (int j = 0; j < N; j++) begin
            if (pool[j]) begin
                d = (j - last - 1 + 2*N) % N;
                if (d < bd) begin
                    bd   = d;
                    best = j;
                end
            end
        end
        return best;
    endfunction

    function automatic logic [N-1:0] oh(input int i);
        return (i < 0) ? '0 : (N'(1) << i);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drop();
        req = '0; hi = '0; end_s = 1'b1;
        step();
        end_s = 1'b0;
    endtask

    task automatic arb_try(input logic [N-1:0] r, input logic [N-1:0] h, input string tag);
        int e;
        req = r; hi = h;
        step();
        e = model_pick(r, h, last_m);
        check(grant_o == oh(e), tag, 32'(grant_o), 32'(oh(e)));
        if (e >= 0) last_m = e;
        drop();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int   g;
        int   o;
        int   k;
        bit   ok;
        s = 32'h1234_5678;

        // R10: reset state
        repeat (3) step();
        check(grant_o == '0, "R10 grant in reset", 32'(grant_o), 0);
        check(tmo_err_o == 1'b0, "R10 tmo in reset", 32'(tmo_err_o), 0);
        rst_n = 1'b1;
        step();
        arb_try(ALL, '0, "R10 port0 first after reset");

        // R2: every holder followed by all-request round
        for (int p = 0; p < N; p++) begin
            arb_try(oh(p), '0, "R4 single requester");
            arb_try(ALL, '0, "R2 next after holder with wrap");
        end

        // R2 example
        arb_try(oh(3), '0, "R4 single requester");
        arb_try(oh(1) | oh(3), '0, "R2 holder3 req1and3");

        // R3: urgent port farthest from pointer still wins
        for (int p = 0; p < N; p++) begin
            arb_try(oh(p), '0, "R4 single requester");
            arb_try(ALL, oh((p + N - 1) % N), "R3 urgent beats pointer");
        end

        // R2 R3 R4: mixed pattern sweep
        for (int i = 0; i < 300; i++) begin
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            arb_try((i % 9 == 0) ? '0 : s[N-1:0], s[16 +: N] & s[21 +: N], "R4 sweep");
        end

        // R5: blocking mode hold, then R6 handover
        wd_en = 1'b0;
        req = oh(2) | oh(7); hi = '0;
        step();
        g = model_pick(req, hi, last_m); last_m = g;
        ok = 1'b1;
        for (int c = 0; c < 40; c++) begin
            req = ALL; xfer = c[0]; hi = (c > 20) ? ALL : '0;
            step();
            if (grant_o != oh(g) || tmo_err_o) ok = 1'b0;
        end
        xfer = 1'b0;
        check(ok, "R5 hold without end", 32'(grant_o), 32'(oh(g)));
        req = oh(2) | oh(7); hi = '0; end_s = 1'b1;
        step();
        end_s = 1'b0;
        o = model_pick(req, hi, last_m);
        check(grant_o == oh(o), "R6 handover next cycle", 32'(grant_o), 32'(oh(o)));
        last_m = o;
        drop();

        // R7 R9: timeout at limit 5
        wd_en = 1'b1; limit = 8'd5;
        req = oh(4) | oh(6);
        step();
        g = model_pick(req, '0, last_m); last_m = g;
        o = (g == 4) ? 6 : 4;
        k = 0;
        for (int c = 1; c <= 20; c++) begin
            step();
            if (k == 0 && grant_o != oh(g)) k = c;
            if (k != 0) break;
        end
        check(k == 5, "R7 withdrawal after 5 idle cycles", 32'(k), 5);
        check(grant_o == oh(o), "R7 rearbitrate on timeout", 32'(grant_o), 32'(oh(o)));
        check(tmo_err_o == 1'b1, "R9 pulse on withdrawal", 32'(tmo_err_o), 1);
        last_m = o;
        step();
        check(tmo_err_o == 1'b0, "R9 pulse lasts one cycle", 32'(tmo_err_o), 0);
        drop();

        // R8: transfer restarts the idle count
        req = oh(4) | oh(6);
        step();
        g = model_pick(req, '0, last_m); last_m = g;
        o = (g == 4) ? 6 : 4;
        repeat (3) step();
        xfer = 1'b1;
        step();
        xfer = 1'b0;
        repeat (4) step();
        check(grant_o == oh(g), "R8 still held after restart", 32'(grant_o), 32'(oh(g)));
        step();
        check(grant_o == oh(o), "R8 withdrawal 5 cycles after transfer", 32'(grant_o), 32'(oh(o)));
        last_m = o;
        drop();

        // R7: limit 0 behaves as 1
        limit = '0;
        req = oh(8) | oh(9);
        step();
        g = model_pick(req, '0, last_m); last_m = g;
        o = (g == 8) ? 9 : 8;
        step();
        check(grant_o == oh(o) && tmo_err_o, "R7 limit zero acts as one",
              {tmo_err_o, 20'(grant_o)}, {1'b1, 20'(oh(o))});
        last_m = o;
        drop();

        // R9: no timeout while disabled
        wd_en = 1'b0; limit = 8'd1;
        req = oh(5);
        step();
        last_m = 5;
        ok = 1'b1;
        for (int c = 0; c < 60; c++) begin
            step();
            if (tmo_err_o || grant_o != oh(5)) ok = 1'b0;
        end
        check(ok, "R9 silent when disabled", 32'(grant_o), 32'(oh(5)));
        drop();
        check(grant_o == '0, "R6 release to idle", 32'(grant_o), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule